// File: doc/BRIEF.md
# LRU Fence Slot Allocator

This block hands out a small, fixed pool of address-detiling slots to a much larger population of surfaces. Each surface is named by an ID. When a client asks for a slot on behalf of a tiled surface, the block returns the slot that surface already holds. If the surface holds none, the block takes the least recently used slot that is not pinned. It evicts whatever surface held that slot before and issues a commit strobe, so that a downstream register programmer can write the slot's descriptor. The encoding of that descriptor is not part of this block.

The block tracks a pin count, a dirty flag, a tiled flag and an owner for every slot. It also keeps a recency order of slot indices. Clients can release a slot, pin or unpin it, and change the tiling of its owner. A restore command re-commits every slot in index order after a reset of the downstream registers. When every slot is pinned, an allocation fails with one of two codes: retry, if a pending release has been signalled, or deadlock otherwise.

Top module: `fence_slot_alloc`

## Requirements
- R1: After reset, every slot is unowned with a pin count of zero, the recency order runs from slot 0 at the least-recently-used head to slot NSLOT-1 at the tail, all outputs are zero and cmd_ready is 1.
- R2: A GET (cmd_op=0) from a surface that owns a clean slot responds with code OK (0), rsp_bound=1 and that slot, and moves the slot to the recency tail. No commit is issued.
- R3: A GET from a surface that owns a dirty slot clears the dirty flag. If the owner is tiled, the block commits a program of that slot (commit_clear=0, commit_id=owner) and moves the slot to the tail. If the owner is untiled, the block commits a clear (commit_clear=1), unbinds the slot, zeroes its pin count and moves it to the head (rsp_bound=0).
- R4: A GET from a tiled surface that owns no slot scans the recency order from the head and takes the first slot whose pin count is zero. It binds the slot to the surface, commits a program, moves the slot to the tail, and responds OK with rsp_bound=1 and the slot.
- R5: If the slot taken under R4 had an owner, evict_valid is 1 together with that owner's ID, and the old owner no longer holds a slot. Taking a free slot gives evict_valid=0.
- R6: If every slot is pinned, a GET that needs an allocation responds with RETRY (1) when pend_release is 1 and DEADLOCK (2) otherwise. It issues no commit and no eviction, and the state does not change.
- R7: A GET from an untiled surface that owns no slot responds OK with rsp_bound=0 and has no other effect.
- R8: A PUT (cmd_op=1) on an owned slot with a nonzero pin count responds BUSY (3) and changes nothing. On an unpinned owned slot it commits a clear, unbinds the slot and moves it to the head. A PUT from a surface that owns no slot responds OK with no action.
- R9: PIN (cmd_op=2) and UNPIN (cmd_op=3) raise or lower the owned slot's pin count, which saturates at zero and at 2^PIN_W-1. They respond OK with rsp_bound=1 and the slot, and have no effect for a surface that owns no slot.
- R10: RETILE (cmd_op=4) sets the owned slot's tiled flag to cmd_tiled and marks the slot dirty, with no commit.
- R11: RESTORE (cmd_op=5) holds cmd_ready low for NSLOT cycles and commits slot i in the (i+1)-th cycle after acceptance. A bound tiled slot is programmed, has its dirty flag cleared and moves to the tail. Any other slot is cleared, unbound, has its pin count zeroed and moves to the head. rsp_valid comes with the last commit.
- R12: Every response, eviction and commit appears one cycle after the command is accepted. Op codes 6 and 7 produce no output and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block accepts a command (low while a restore walk runs) |
| cmd_op | input | 3 | 0 GET, 1 PUT, 2 PIN, 3 UNPIN, 4 RETILE, 5 RESTORE |
| cmd_id | input | ID_W | Surface ID |
| cmd_tiled | input | 1 | Surface is tiled (GET without a slot, RETILE) |
| pend_release | input | 1 | A slot release is pending elsewhere |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 OK, 1 RETRY, 2 DEADLOCK, 3 BUSY |
| rsp_bound | output | 1 | Surface holds a slot after the command |
| rsp_slot | output | SW | Slot concerned, 0 if none |
| evict_valid | output | 1 | A previous owner lost its slot |
| evict_id | output | ID_W | ID of the evicted owner |
| commit_valid | output | 1 | Register programming strobe |
| commit_clear | output | 1 | 1 clears the slot, 0 programs it |
| commit_slot | output | SW | Slot to program or clear |
| commit_id | output | ID_W | Surface to program into the slot (0 on clear) |

## Verification
A command that is present at a clock edge while cmd_ready is high has its response, eviction and commit in the registers right after that edge. The bench drives inputs on the falling edge and compares every output 1 ns after the next rising edge against a behavioural model that was advanced once for that cycle. A restore walk produces one commit per cycle for NSLOT cycles with the response on the last. The model counts those cycles and ignores commands offered while it is busy, and the bench checks cmd_ready before each edge against the model's walk state.

// File: rtl/fence_alloc_pkg.sv
package fence_alloc_pkg;
  typedef enum logic [2:0] {
    OP_GET     = 3'd0,
    OP_PUT     = 3'd1,
    OP_PIN     = 3'd2,
    OP_UNPIN   = 3'd3,
    OP_RETILE  = 3'd4,
    OP_RESTORE = 3'd5
  } fop_e;

  typedef enum logic [1:0] {
    RC_OK       = 2'd0,
    RC_RETRY    = 2'd1,
    RC_DEADLOCK = 2'd2,
    RC_BUSY     = 2'd3
  } frc_e;
endpackage

// File: rtl/fence_lookup.sv
module fence_lookup #(
  parameter int NSLOT = 8,
  parameter int ID_W  = 6,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOT-1:0]      bound,
  input  logic [NSLOT*ID_W-1:0] owners,
  input  logic [ID_W-1:0]       key,
  output logic                  hit,
  output logic [SW-1:0]         slot
);
  logic [NSLOT-1:0] match;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign match[g] = bound[g] && (owners[g*ID_W +: ID_W] == key);
  end

  always_comb begin
    hit  = |match;
    slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (match[i]) slot = SW'(i);
    end
  end

  // R5: an eviction must leave each surface with at most one slot
  a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/fence_victim.sv
module fence_victim #(
  parameter int NSLOT = 8,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSLOT*SW-1:0] order,
  input  logic [NSLOT-1:0]    pin_zero,
  output logic                found,
  output logic [SW-1:0]       slot
);
  // scan from the tail toward the head so the head-most unpinned slot wins
  always_comb begin
    found = 1'b0;
    slot  = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (pin_zero[order[k*SW +: SW]]) begin
        found = 1'b1;
        slot  = order[k*SW +: SW];
      end
    end
  end

  a_r4_victim_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> pin_zero[slot]);

  a_r6_none_free_all_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (pin_zero == '0));
endmodule

// File: rtl/fence_recency.sv
module fence_recency #(
  parameter int NSLOT = 8,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mv_en,
  input  logic [SW-1:0]       mv_slot,
  input  logic                mv_tail,
  output logic [NSLOT*SW-1:0] order_flat
);
  logic [SW-1:0] ord_q [NSLOT];
  logic [SW-1:0] ord_d [NSLOT];
  logic [SW-1:0] pos;

  always_comb begin
    pos = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (ord_q[k] == mv_slot) pos = SW'(k);
    end
  end

  always_comb begin
    for (int k = 0; k < NSLOT; k++) begin
      ord_d[k] = ord_q[k];
      if (mv_en && mv_tail && (k >= int'(pos))) begin
        ord_d[k] = (k == NSLOT - 1) ? mv_slot : ord_q[(k + 1) % NSLOT];
      end else if (mv_en && !mv_tail && (k <= int'(pos))) begin
        ord_d[k] = (k == 0) ? mv_slot : ord_q[(k + NSLOT - 1) % NSLOT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT; k++) ord_q[k] <= SW'(k);
    end else if (mv_en) begin
      for (int k = 0; k < NSLOT; k++) ord_q[k] <= ord_d[k];
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_out
    assign order_flat[g*SW +: SW] = ord_q[g];
  end

  logic [NSLOT-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < NSLOT; k++) seen[ord_q[k]] = 1'b1;
  end

  a_r4_order_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    seen == '1);

  a_r4_moved_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_en && mv_tail) |=> (order_flat[(NSLOT-1)*SW +: SW] == $past(mv_slot)));

  a_r8_moved_to_head: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_en && !mv_tail) |=> (order_flat[SW-1:0] == $past(mv_slot)));
endmodule

// File: rtl/fence_slot_alloc.sv
module fence_slot_alloc
  import fence_alloc_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int ID_W  = 6,
  parameter int PIN_W = 3,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [ID_W-1:0] cmd_id,
  input  logic            cmd_tiled,
  input  logic            pend_release,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  output logic            rsp_bound,
  output logic [SW-1:0]   rsp_slot,
  output logic            evict_valid,
  output logic [ID_W-1:0] evict_id,
  output logic            commit_valid,
  output logic            commit_clear,
  output logic [SW-1:0]   commit_slot,
  output logic [ID_W-1:0] commit_id
);
  localparam logic [PIN_W-1:0] PIN_MAX = '1;

  // slot table
  logic [ID_W-1:0]  owner_q [NSLOT];
  logic [ID_W-1:0]  owner_d [NSLOT];
  logic [PIN_W-1:0] pin_q   [NSLOT];
  logic [PIN_W-1:0] pin_d   [NSLOT];
  logic [NSLOT-1:0] bound_q, bound_d, tiled_q, tiled_d, dirty_q, dirty_d;
  logic             walk_q, walk_d;
  logic [SW-1:0]    widx_q, widx_d;

  // registered outputs
  logic            rv_q, rv_d, rb_q, rb_d, ev_q, ev_d, cv_q, cv_d, cc_q, cc_d;
  frc_e            rc_q, rc_d;
  logic [SW-1:0]   rs_q, rs_d, cs_q, cs_d;
  logic [ID_W-1:0] eid_q, eid_d, cid_q, cid_d;

  // helpers
  logic [NSLOT*ID_W-1:0] owners_flat;
  logic [NSLOT-1:0]      pin_zero;
  logic [NSLOT*SW-1:0]   order_flat;
  logic                  lk_hit, vic_found;
  logic [SW-1:0]         lk_slot, vic_slot;
  logic                  mv_en, mv_tail;
  logic [SW-1:0]         mv_slot;
  logic                  acc, tbl_en;

  for (genvar g = 0; g < NSLOT; g++) begin : g_flat
    assign owners_flat[g*ID_W +: ID_W] = owner_q[g];
    assign pin_zero[g] = (pin_q[g] == '0);
  end

  assign cmd_ready = !walk_q;
  assign acc       = cmd_valid && !walk_q;
  assign tbl_en    = acc || walk_q;

  fence_lookup #(.NSLOT(NSLOT), .ID_W(ID_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .bound(bound_q), .owners(owners_flat),
    .key(cmd_id), .hit(lk_hit), .slot(lk_slot));

  fence_victim #(.NSLOT(NSLOT)) u_victim (
    .clk(clk), .rst_n(rst_n), .order(order_flat), .pin_zero(pin_zero),
    .found(vic_found), .slot(vic_slot));

  fence_recency #(.NSLOT(NSLOT)) u_recency (
    .clk(clk), .rst_n(rst_n), .mv_en(mv_en), .mv_slot(mv_slot),
    .mv_tail(mv_tail), .order_flat(order_flat));

  // next-state
  always_comb begin
    owner_d = owner_q;
    pin_d   = pin_q;
    bound_d = bound_q;
    tiled_d = tiled_q;
    dirty_d = dirty_q;
    walk_d  = walk_q;
    widx_d  = widx_q;
    mv_en   = 1'b0;
    mv_tail = 1'b0;
    mv_slot = '0;
    rv_d = 1'b0; rc_d = RC_OK; rb_d = 1'b0; rs_d = '0;
    ev_d = 1'b0; eid_d = '0;
    cv_d = 1'b0; cc_d = 1'b0; cs_d = '0; cid_d = '0;

    if (walk_q) begin
      cv_d             = 1'b1;
      cs_d             = widx_q;
      dirty_d[widx_q]  = 1'b0;
      mv_en            = 1'b1;
      mv_slot          = widx_q;
      if (bound_q[widx_q] && tiled_q[widx_q]) begin
        cid_d   = owner_q[widx_q];
        mv_tail = 1'b1;
      end else begin
        cc_d            = 1'b1;
        bound_d[widx_q] = 1'b0;
        pin_d[widx_q]   = '0;
      end
      if (widx_q == SW'(NSLOT - 1)) begin
        walk_d = 1'b0;
        rv_d   = 1'b1;
      end
      widx_d = widx_q + 1'b1;
    end else if (cmd_valid) begin
      case (fop_e'(cmd_op))
        OP_GET: begin
          rv_d = 1'b1;
          if (lk_hit) begin
            rs_d    = lk_slot;
            mv_en   = 1'b1;
            mv_slot = lk_slot;
            if (!dirty_q[lk_slot]) begin
              rb_d    = 1'b1;
              mv_tail = 1'b1;
            end else if (tiled_q[lk_slot]) begin
              rb_d             = 1'b1;
              mv_tail          = 1'b1;
              cv_d             = 1'b1;
              cs_d             = lk_slot;
              cid_d            = cmd_id;
              dirty_d[lk_slot] = 1'b0;
            end else begin
              cv_d             = 1'b1;
              cc_d             = 1'b1;
              cs_d             = lk_slot;
              bound_d[lk_slot] = 1'b0;
              dirty_d[lk_slot] = 1'b0;
              pin_d[lk_slot]   = '0;
            end
          end else if (cmd_tiled) begin
            if (!vic_found) begin
              rc_d = pend_release ? RC_RETRY : RC_DEADLOCK;
            end else begin
              rb_d              = 1'b1;
              rs_d              = vic_slot;
              ev_d              = bound_q[vic_slot];
              eid_d             = bound_q[vic_slot] ? owner_q[vic_slot] : '0;
              owner_d[vic_slot] = cmd_id;
              bound_d[vic_slot] = 1'b1;
              tiled_d[vic_slot] = 1'b1;
              dirty_d[vic_slot] = 1'b0;
              cv_d              = 1'b1;
              cs_d              = vic_slot;
              cid_d             = cmd_id;
              mv_en             = 1'b1;
              mv_slot           = vic_slot;
              mv_tail           = 1'b1;
            end
          end
        end
        OP_PUT: begin
          rv_d = 1'b1;
          if (lk_hit) begin
            rs_d = lk_slot;
            if (pin_q[lk_slot] != '0) begin
              rc_d = RC_BUSY;
              rb_d = 1'b1;
            end else begin
              cv_d             = 1'b1;
              cc_d             = 1'b1;
              cs_d             = lk_slot;
              bound_d[lk_slot] = 1'b0;
              dirty_d[lk_slot] = 1'b0;
              mv_en            = 1'b1;
              mv_slot          = lk_slot;
            end
          end
        end
        OP_PIN: begin
          rv_d = 1'b1;
          if (lk_hit) begin
            rs_d = lk_slot;
            rb_d = 1'b1;
            if (pin_q[lk_slot] != PIN_MAX) pin_d[lk_slot] = pin_q[lk_slot] + PIN_W'(1);
          end
        end
        OP_UNPIN: begin
          rv_d = 1'b1;
          if (lk_hit) begin
            rs_d = lk_slot;
            rb_d = 1'b1;
            if (pin_q[lk_slot] != '0) pin_d[lk_slot] = pin_q[lk_slot] - PIN_W'(1);
          end
        end
        OP_RETILE: begin
          rv_d = 1'b1;
          if (lk_hit) begin
            rs_d             = lk_slot;
            rb_d             = 1'b1;
            tiled_d[lk_slot] = cmd_tiled;
            dirty_d[lk_slot] = 1'b1;
          end
        end
        OP_RESTORE: begin
          walk_d = 1'b1;
          widx_d = '0;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT; k++) begin
        owner_q[k] <= '0;
        pin_q[k]   <= '0;
      end
      bound_q <= '0;
      tiled_q <= '0;
      dirty_q <= '0;
    end else if (tbl_en) begin
      for (int k = 0; k < NSLOT; k++) begin
        owner_q[k] <= owner_d[k];
        pin_q[k]   <= pin_d[k];
      end
      bound_q <= bound_d;
      tiled_q <= tiled_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_q <= 1'b0;
      widx_q <= '0;
      rv_q <= 1'b0; rc_q <= RC_OK; rb_q <= 1'b0; rs_q <= '0;
      ev_q <= 1'b0; eid_q <= '0;
      cv_q <= 1'b0; cc_q <= 1'b0; cs_q <= '0; cid_q <= '0;
    end else begin
      walk_q <= walk_d;
      widx_q <= widx_d;
      rv_q <= rv_d; rc_q <= rc_d; rb_q <= rb_d; rs_q <= rs_d;
      ev_q <= ev_d; eid_q <= eid_d;
      cv_q <= cv_d; cc_q <= cc_d; cs_q <= cs_d; cid_q <= cid_d;
    end
  end

  assign rsp_valid    = rv_q;
  assign rsp_code     = rc_q;
  assign rsp_bound    = rb_q;
  assign rsp_slot     = rs_q;
  assign evict_valid  = ev_q;
  assign evict_id     = eid_q;
  assign commit_valid = cv_q;
  assign commit_clear = cc_q;
  assign commit_slot  = cs_q;
  assign commit_id    = cid_q;

  a_r2_clean_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_GET && lk_hit && !dirty_q[lk_slot])
      |=> (rsp_valid && rsp_bound && !commit_valid));

  a_r5_evict_with_program: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (commit_valid && !commit_clear && commit_slot == rsp_slot));

  a_r6_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_code == RC_RETRY || rsp_code == RC_DEADLOCK))
      |-> (!commit_valid && !evict_valid && !rsp_bound));

  a_r8_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_BUSY) |-> (!commit_valid && rsp_bound));

  a_r11_walk_commits: assert property (@(posedge clk) disable iff (!rst_n)
    walk_q |=> commit_valid);

  a_r12_unknown_op_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op > 3'd5) |=> (!rsp_valid && !commit_valid && !evict_valid));
endmodule

// File: tb/fence_slot_alloc_test.sv
`timescale 1ns/1ps
module fence_slot_alloc_test;
  localparam int N     = 8;
  localparam int ID_W  = 6;
  localparam int PIN_W = 3;
  localparam int SW    = $clog2(N);
  localparam int PMAX  = (1 << PIN_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_tiled, pend_release;
  logic [2:0] cmd_op;
  logic [ID_W-1:0] cmd_id;
  logic cmd_ready, rsp_valid, rsp_bound, evict_valid, commit_valid, commit_clear;
  logic [1:0] rsp_code;
  logic [SW-1:0] rsp_slot, commit_slot;
  logic [ID_W-1:0] evict_id, commit_id;

  always #2 clk = ~clk;

  fence_slot_alloc #(.NSLOT(N), .ID_W(ID_W), .PIN_W(PIN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_tiled(cmd_tiled),
    .pend_release(pend_release), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_bound(rsp_bound), .rsp_slot(rsp_slot), .evict_valid(evict_valid),
    .evict_id(evict_id), .commit_valid(commit_valid), .commit_clear(commit_clear),
    .commit_slot(commit_slot), .commit_id(commit_id));

  int checks = 0;
  int fails  = 0;

  // behavioural model
  int m_owner [N];
  bit m_bound [N];
  bit m_tiled [N];
  bit m_dirty [N];
  int m_pin   [N];
  int m_ord [$];
  bit m_walk;
  int m_widx;
  int e_rv, e_code, e_bound, e_slot, e_ev, e_eid, e_cv, e_cc, e_cs, e_cid;

  task automatic model_reset();
    m_ord.delete();
    for (int i = 0; i < N; i++) begin
      m_owner[i] = 0; m_bound[i] = 0; m_tiled[i] = 0; m_dirty[i] = 0; m_pin[i] = 0;
      m_ord.push_back(i);
    end
    m_walk = 0; m_widx = 0;
  endtask

  task automatic mv(input int s, input bit tail);
    for (int k = 0; k < m_ord.size(); k++) begin
      if (m_ord[k] == s) begin
        m_ord.delete(k);
        break;
      end
    end
    if (tail) m_ord.push_back(s); else m_ord.push_front(s);
  endtask

  task automatic model_step(input bit cv, input int op, input int id, input bit tl, input bit pd);
    int h;
    int v;
    e_rv = 0; e_code = 0; e_bound = 0; e_slot = 0; e_ev = 0; e_eid = 0;
    e_cv = 0; e_cc = 0; e_cs = 0; e_cid = 0;
    if (m_walk) begin
      e_cv = 1; e_cs = m_widx; m_dirty[m_widx] = 0;
      if (m_bound[m_widx] && m_tiled[m_widx]) begin
        e_cid = m_owner[m_widx]; mv(m_widx, 1);
      end else begin
        e_cc = 1; m_bound[m_widx] = 0; m_pin[m_widx] = 0; mv(m_widx, 0);
      end
      if (m_widx == N - 1) begin m_walk = 0; e_rv = 1; end
      m_widx++;
      return;
    end
    if (!cv) return;
    h = -1;
    for (int i = 0; i < N; i++) if (m_bound[i] && m_owner[i] == id) h = i;
    case (op)
      0: begin
        e_rv = 1;
        if (h >= 0) begin
          e_slot = h;
          if (!m_dirty[h]) begin e_bound = 1; mv(h, 1); end
          else if (m_tiled[h]) begin
            e_bound = 1; e_cv = 1; e_cs = h; e_cid = id; m_dirty[h] = 0; mv(h, 1);
          end else begin
            e_cv = 1; e_cc = 1; e_cs = h; m_bound[h] = 0; m_dirty[h] = 0; m_pin[h] = 0; mv(h, 0);
          end
        end else if (tl) begin
          v = -1;
          foreach (m_ord[k]) if (v < 0 && m_pin[m_ord[k]] == 0) v = m_ord[k];
          if (v < 0) e_code = pd ? 1 : 2;
          else begin
            e_bound = 1; e_slot = v;
            if (m_bound[v]) begin e_ev = 1; e_eid = m_owner[v]; end
            m_owner[v] = id; m_bound[v] = 1; m_tiled[v] = 1; m_dirty[v] = 0;
            e_cv = 1; e_cs = v; e_cid = id; mv(v, 1);
          end
        end
      end
      1: begin
        e_rv = 1;
        if (h >= 0) begin
          e_slot = h;
          if (m_pin[h] != 0) begin e_code = 3; e_bound = 1; end
          else begin
            e_cv = 1; e_cc = 1; e_cs = h; m_bound[h] = 0; m_dirty[h] = 0; mv(h, 0);
          end
        end
      end
      2, 3: begin
        e_rv = 1;
        if (h >= 0) begin
          e_slot = h; e_bound = 1;
          if (op == 2 && m_pin[h] < PMAX) m_pin[h]++;
          if (op == 3 && m_pin[h] > 0) m_pin[h]--;
        end
      end
      4: begin
        e_rv = 1;
        if (h >= 0) begin
          e_slot = h; e_bound = 1; m_tiled[h] = tl; m_dirty[h] = 1;
        end
      end
      5: begin m_walk = 1; m_widx = 0; end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag, input bit rdy_ok, input bit rdy_exp);
    checks++;
    if (!rdy_ok || rsp_valid !== e_rv[0] || rsp_code !== e_code[1:0] ||
        rsp_bound !== e_bound[0] || rsp_slot !== e_slot[SW-1:0] ||
        evict_valid !== e_ev[0] || evict_id !== e_eid[ID_W-1:0] ||
        commit_valid !== e_cv[0] || commit_clear !== e_cc[0] ||
        commit_slot !== e_cs[SW-1:0] || commit_id !== e_cid[ID_W-1:0]) begin
      fails++;
      $display("FAIL %s: actual rdy_ok=%0b rv=%0b code=%0d bound=%0b slot=%0d ev=%0b eid=%0d cv=%0b cc=%0b cs=%0d cid=%0d expected rdy=%0b rv=%0d code=%0d bound=%0d slot=%0d ev=%0d eid=%0d cv=%0d cc=%0d cs=%0d cid=%0d",
               tag, rdy_ok, rsp_valid, rsp_code, rsp_bound, rsp_slot, evict_valid, evict_id,
               commit_valid, commit_clear, commit_slot, commit_id,
               rdy_exp, e_rv, e_code, e_bound, e_slot, e_ev, e_eid, e_cv, e_cc, e_cs, e_cid);
    end
  endtask

  task automatic cyc(input bit cv, input int op, input int id, input bit tl, input bit pd, input string tag);
    bit rdy_exp;
    bit rdy_ok;
    @(negedge clk);
    cmd_valid = cv; cmd_op = op[2:0]; cmd_id = id[ID_W-1:0]; cmd_tiled = tl; pend_release = pd;
    #0.5;
    rdy_exp = !m_walk;
    rdy_ok  = (cmd_ready === rdy_exp);
    model_step(cv, op, id, tl, pd);
    @(posedge clk);
    #1;
    compare(tag, rdy_ok, rdy_exp);
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R4";
      1: return "R8";
      2, 3: return "R9";
      4: return "R10";
      5: return "R11";
      default: return "R12";
    endcase
  endfunction

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_id = 0; cmd_tiled = 0; pend_release = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cyc(0, 0, 0, 0, 0, "R1");                     // reset state
    for (int i = 0; i < N; i++) cyc(1, 0, 10 + i, 1, 0, (i == 0) ? "R1" : "R4");
    cyc(1, 0, 12, 1, 0, "R2");                    // clean hit
    cyc(1, 0, 20, 1, 0, "R5");                    // evicts head owner
    cyc(1, 2, 11, 0, 0, "R9");                    // pin the new head
    cyc(1, 0, 21, 1, 0, "R4");                    // skips pinned slot
    cyc(1, 1, 11, 0, 0, "R8");                    // busy
    cyc(1, 3, 11, 0, 0, "R9");
    cyc(1, 1, 11, 0, 0, "R8");                    // release to head
    cyc(1, 0, 22, 1, 0, "R5");                    // free slot, no eviction
    cyc(1, 4, 22, 0, 0, "R10");
    cyc(1, 0, 22, 1, 0, "R3");                    // dirty untiled -> clear
    cyc(1, 4, 20, 1, 0, "R10");
    cyc(1, 0, 20, 1, 0, "R3");                    // dirty tiled -> program
    cyc(1, 0, 20, 1, 0, "R2");                    // now clean
    cyc(1, 0, 40, 0, 0, "R7");
    cyc(1, 1, 41, 0, 0, "R8");                    // no owner
    for (int i = 0; i < N; i++) cyc(1, 0, 30 + i, 1, 0, "R5");
    for (int i = 0; i < N; i++) cyc(1, 2, 30 + i, 0, 0, "R9");
    cyc(1, 0, 50, 1, 0, "R6");                    // deadlock
    cyc(1, 0, 50, 1, 1, "R6");                    // retry
    for (int i = 0; i < N; i++) cyc(1, 2, 30, 0, 0, "R9");
    for (int i = 0; i < N + 1; i++) cyc(1, 3, 30, 0, 0, "R9");
    cyc(1, 1, 30, 0, 0, "R8");
    cyc(1, 4, 31, 0, 0, "R10");
    cyc(1, 5, 0, 0, 0, "R11");
    for (int i = 0; i < N + 1; i++) cyc(1, 0, 60, 1, 0, "R11");
    cyc(1, 6, 33, 1, 0, "R12");
    cyc(1, 7, 34, 1, 0, "R12");

    for (int n = 0; n < 600; n++) begin
      int op;
      int r;
      r = int'($urandom_range(0, 19));
      op = (r < 6) ? 0 : (r < 9) ? 2 : (r < 11) ? 3 : (r < 14) ? 1 : (r < 17) ? 4 :
           (r < 18) ? 5 : 6;
      cyc(1'($urandom_range(0, 5) != 0), op, int'($urandom_range(0, 11)),
          1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), tag_of(op));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule